// File: doc/BRIEF.md
# DMA Request Line to Channel Router

This block sits between the peripherals of a chip and its bank of DMA channel engines. Every peripheral raises its own request line. Software decides which channel serves which peripheral by writing one small routing entry per request line. Each entry holds an enable flag and a channel number. The block then drives, for every channel, a request that is the OR of all request lines routed to it through an enabled entry.

The entries are reached through a simple synchronous register port. Request lines are split by number across two address windows:

- The lower half of the request numbers is at offset 0x100.
- The upper half is at offset 0x1100.

Within each window the entries are one 32-bit word apart. Clearing an entry to zero takes its request line off every channel, so software can move a peripheral to another channel, or retire it, without touching the other routes.

Top module: `dma_req_mapper`

## Requirements
- R1: While reset is asserted, and right after it, every entry is disabled, `chan_req` is all zero and `cfg_rdata` is zero, even with every request line high.
- R2: In an entry, bit 7 is the enable flag and bits [4:0] are the channel number. When the entry for request line r is enabled with channel c, a high level on `req_in[r]` raises `chan_req[c]`.
- R3: When an entry's enable flag is clear, its request line reaches no channel, whatever channel number the entry holds.
- R4: `chan_req[c]` is the OR of all request lines whose entry is enabled and names c. One request line never raises more than one channel.
- R5: The entry for request r is at byte address 0x100 + 4*r for r in 0..63, and at 0x1100 + 4*(r-64) for r in 64..127.
- R6: Writing zero to an entry removes its request line from every channel.
- R7: A read returns the enable flag in bit 7 and the channel number in bits [4:0]. All other bits read as zero, including bits [6:5] after a write of all ones.
- R8: An access to an address outside both windows, or with address bits [1:0] not zero, changes no entry, and a read there returns zero.
- R9: `chan_req` is registered. Its value after a rising edge reflects `req_in` and the entries as they were just before that edge. A new entry therefore takes effect on the edge after the one that writes it.
- R10: A read takes effect on the edge where `cfg_rd_en` is high. A read and a write to the same entry on the same edge return the contents from before the write.
- R11: `cfg_rdata` keeps its value on every edge where `cfg_rd_en` is low.
- R12: Rewriting an enabled entry with a new channel moves its request line to the new channel and drops it from the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_addr | input | 16 | Byte address of the register access |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| req_in | input | 128 | Peripheral request lines |
| chan_req | output | 32 | Per-channel combined request |

## Verification
The hardest states to reach from the ports are those where several enabled entries name one channel while other request lines sit in disabled entries that still hold the same channel number. The OR and the enable gating must then be told apart on one output bit. A directed sequence builds this case across both address windows. It then rewires one entry, clears it, and reads and writes one entry on the same edge. After that, a long random phase mixes writes to valid and invalid addresses with sparse request patterns. A behavioural model is compared with `chan_req` and `cfg_rdata` on every clock.

// File: rtl/dma_req_mapper_pkg.sv
package dma_req_mapper_pkg;

    localparam int CH_FIELD_W = 5;
    localparam int VLD_BIT    = 7;
    localparam int BANK_SIZE  = 64;

    localparam logic [15:0] LO_BASE = 16'h0100;
    localparam logic [15:0] HI_BASE = 16'h1100;

    typedef struct packed {
        logic                  vld;
        logic [CH_FIELD_W-1:0] ch;
    } map_entry_t;

    // Byte image of an entry as seen on the register port
    function automatic logic [7:0] entry_to_byte(map_entry_t e);
        return {e.vld, 2'b00, e.ch};
    endfunction

endpackage

// File: rtl/dma_req_mapper_decode.sv
module dma_req_mapper_decode
    import dma_req_mapper_pkg::*;
#(
    parameter int NUM_REQ = 128,
    parameter int ADDR_W  = 16,
    localparam int IDX_W  = $clog2(NUM_REQ)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);

    localparam logic [ADDR_W-1:0] LO_PAGE = ADDR_W'(LO_BASE);
    localparam logic [ADDR_W-1:0] HI_PAGE = ADDR_W'(HI_BASE);

    logic [ADDR_W-1:0] page;
    logic              in_lo;
    logic              in_hi;
    logic [6:0]        full_idx;

    always_comb begin
        page     = {addr[ADDR_W-1:8], 8'h00};
        in_lo    = (page == LO_PAGE);
        in_hi    = (page == HI_PAGE);
        full_idx = {in_hi, addr[7:2]};
        hit      = (in_lo || in_hi) && (addr[1:0] == 2'b00)
                   && ({25'd0, full_idx} < 32'(NUM_REQ));
        idx      = full_idx[IDX_W-1:0];
    end

endmodule

// File: rtl/dma_req_mapper_regs.sv
module dma_req_mapper_regs
    import dma_req_mapper_pkg::*;
#(
    parameter int NUM_REQ = 128,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = $clog2(NUM_REQ)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic                     hit,
    input  logic [IDX_W-1:0]         idx,
    input  logic [7:0]               wbyte,
    output map_entry_t [NUM_REQ-1:0] map,
    output logic [DATA_W-1:0]        rdata
);

    typedef struct packed {
        map_entry_t [NUM_REQ-1:0] map;
        logic [DATA_W-1:0]        rdata;
    } regs_st_t;

    regs_st_t st_d;
    regs_st_t st_q;

    always_comb begin
        st_d = st_q;
        // Read samples the pre-write contents
        if (rd_en) begin
            st_d.rdata = hit ? DATA_W'(entry_to_byte(st_q.map[idx])) : '0;
        end
        if (wr_en && hit) begin
            st_d.map[idx].vld = wbyte[VLD_BIT];
            st_d.map[idx].ch  = wbyte[CH_FIELD_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign map   = st_q.map;
    assign rdata = st_q.rdata;

endmodule

// File: rtl/dma_req_mapper_route.sv
module dma_req_mapper_route
    import dma_req_mapper_pkg::*;
#(
    parameter int NUM_REQ  = 128,
    parameter int NUM_CHAN = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_REQ-1:0]       req_in,
    input  map_entry_t [NUM_REQ-1:0] map,
    output logic [NUM_CHAN-1:0]      chan_req
);

    typedef struct packed {
        logic [NUM_CHAN-1:0] req;
    } route_st_t;

    route_st_t           st_d;
    route_st_t           st_q;
    logic [NUM_CHAN-1:0] chan_any;

    // One OR tree per channel over all enabled, matching request lines
    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        logic [NUM_REQ-1:0] sel;
        always_comb begin
            for (int r = 0; r < NUM_REQ; r++) begin
                sel[r] = req_in[r] && map[r].vld
                         && (map[r].ch == CH_FIELD_W'(c));
            end
        end
        assign chan_any[c] = |sel;
    end

    always_comb begin
        st_d     = st_q;
        st_d.req = chan_any;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chan_req = st_q.req;

endmodule

// File: rtl/dma_req_mapper.sv
module dma_req_mapper
    import dma_req_mapper_pkg::*;
#(
    parameter int NUM_REQ  = 128,
    parameter int NUM_CHAN = 32,
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic                cfg_rd_en,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [DATA_W-1:0]   cfg_wdata,
    output logic [DATA_W-1:0]   cfg_rdata,
    input  logic [NUM_REQ-1:0]  req_in,
    output logic [NUM_CHAN-1:0] chan_req
);

    localparam int IDX_W = $clog2(NUM_REQ);

    logic                     acc_hit;
    logic [IDX_W-1:0]         acc_idx;
    map_entry_t [NUM_REQ-1:0] map;
    logic                     unused_wdata;

    assign unused_wdata = ^{cfg_wdata[DATA_W-1:8], cfg_wdata[6:5]};

    dma_req_mapper_decode #(
        .NUM_REQ (NUM_REQ),
        .ADDR_W  (ADDR_W)
    ) u_decode (
        .addr (cfg_addr),
        .hit  (acc_hit),
        .idx  (acc_idx)
    );

    dma_req_mapper_regs #(
        .NUM_REQ (NUM_REQ),
        .DATA_W  (DATA_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr_en),
        .rd_en (cfg_rd_en),
        .hit   (acc_hit),
        .idx   (acc_idx),
        .wbyte (cfg_wdata[7:0]),
        .map   (map),
        .rdata (cfg_rdata)
    );

    dma_req_mapper_route #(
        .NUM_REQ  (NUM_REQ),
        .NUM_CHAN (NUM_CHAN)
    ) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_in   (req_in),
        .map      (map),
        .chan_req (chan_req)
    );

endmodule

// File: rtl/dma_req_mapper_chk.sv
module dma_req_mapper_chk #(
    parameter int NUM_REQ  = 128,
    parameter int NUM_CHAN = 32,
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_wr_en,
    input logic                cfg_rd_en,
    input logic [ADDR_W-1:0]   cfg_addr,
    input logic [DATA_W-1:0]   cfg_wdata,
    input logic [DATA_W-1:0]   cfg_rdata,
    input logic [NUM_REQ-1:0]  req_in,
    input logic [NUM_CHAN-1:0] chan_req
);

    // Address lies on a real entry (range form, written apart from the decoder)
    function automatic logic addr_ok(logic [ADDR_W-1:0] a);
        int v;
        v = int'(a);
        if (v % 4 != 0) return 1'b0;
        if (v >= 'h100 && v < 'h200 && (v - 'h100) / 4 < NUM_REQ) return 1'b1;
        if (v >= 'h1100 && v < 'h1200 && 64 + (v - 'h1100) / 4 < NUM_REQ) return 1'b1;
        return 1'b0;
    endfunction

    // R1: outputs quiet while reset is held
    always @(negedge clk) begin
        if (rst_n == 1'b0) begin
            a_r1_reset_quiet: assert (chan_req == '0 && cfg_rdata == '0);
        end
    end

    // R4: one request line raises at most one channel
    a_r4_no_fanout: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $countones(chan_req) <= $countones($past(req_in)));

    // R9: no request in means no channel request one edge later
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_in == '0 |=> chan_req == '0);

    // R7: unused read data bits are zero
    a_r7_rdata_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_en |=> cfg_rdata[DATA_W-1:8] == '0 && cfg_rdata[6:5] == 2'b00);

    // R8: reads outside the windows return zero
    a_r8_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_en && !addr_ok(cfg_addr) |=> cfg_rdata == '0);

    // R11: read data holds without a read
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd_en |=> $stable(cfg_rdata));

    // R10: a write followed by a read of the same entry returns the written byte
    a_r10_write_then_read: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en && !cfg_rd_en && addr_ok(cfg_addr)
        ##1 cfg_rd_en && !cfg_wr_en && cfg_addr == $past(cfg_addr)
        |=> cfg_rdata == DATA_W'({$past(cfg_wdata[7], 2), 2'b00, $past(cfg_wdata[4:0], 2)}));

endmodule

bind dma_req_mapper dma_req_mapper_chk #(
    .NUM_REQ  (NUM_REQ),
    .NUM_CHAN (NUM_CHAN),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_en (cfg_wr_en),
    .cfg_rd_en (cfg_rd_en),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .req_in    (req_in),
    .chan_req  (chan_req)
);

// File: tb/sim_dma_req_mapper.sv
module sim_dma_req_mapper;

    localparam int NREQ = 128;
    localparam int NCH  = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b1;
    logic            wr = 1'b0;
    logic            rd = 1'b0;
    logic [15:0]     addr = '0;
    logic [31:0]     wdata = '0;
    logic [NREQ-1:0] req = '0;
    logic [31:0]     rdata;
    logic [NCH-1:0]  chan;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    int          m_vld [NREQ];
    int          m_ch  [NREQ];
    logic [NCH-1:0] exp_chan = '0;
    logic [31:0]    exp_rdata = '0;

    always #5 clk = ~clk;

    dma_req_mapper u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr_en (wr),
        .cfg_rd_en (rd),
        .cfg_addr  (addr),
        .cfg_wdata (wdata),
        .cfg_rdata (rdata),
        .req_in    (req),
        .chan_req  (chan)
    );

    function automatic logic [15:0] addr_of(int r);
        if (r < 64) return 16'(32'h100 + 4 * r);
        return 16'(32'h1100 + 4 * (r - 64));
    endfunction

    // Request index for an address, -1 when it hits no entry (R5, R8)
    function automatic int req_of(logic [15:0] a);
        int v;
        v = int'(a);
        if (v % 4 != 0) return -1;
        if (v >= 'h100 && v < 'h200) return (v - 'h100) / 4;
        if (v >= 'h1100 && v < 'h1200) return 64 + (v - 'h1100) / 4;
        return -1;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: advance the model at the edge, compare after it
    task automatic cyc(string tag);
        int mi;
        @(posedge clk);
        exp_chan = '0;
        for (int r = 0; r < NREQ; r++) begin
            if (req[r] && m_vld[r] != 0 && m_ch[r] < NCH) exp_chan[m_ch[r]] = 1'b1;
        end
        if (rd) begin
            mi = req_of(addr);
            exp_rdata = (mi < 0) ? 32'h0 : {24'h0, m_vld[mi][0], 2'b00, m_ch[mi][4:0]};
        end
        if (wr) begin
            mi = req_of(addr);
            if (mi >= 0) begin
                m_vld[mi] = int'(wdata[7]);
                m_ch[mi]  = int'(wdata[4:0]);
            end
        end
        @(negedge clk);
        chk({tag, " chan_req"}, 32'(chan), 32'(exp_chan));
        chk({tag, " rdata"}, rdata, exp_rdata);
    endtask

    task automatic wreg(logic [15:0] a, logic [31:0] d, string tag);
        wr = 1'b1; addr = a; wdata = d;
        cyc(tag);
        wr = 1'b0;
    endtask

    task automatic rreg(logic [15:0] a, string tag);
        rd = 1'b1; addr = a;
        cyc(tag);
        rd = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung run, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NREQ; r++) begin m_vld[r] = 0; m_ch[r] = 0; end
        rst_n = 1'b0;
        req = '1;
        repeat (3) @(negedge clk);
        // R1: quiet during reset with all requests high
        chk("R1 reset chan_req", 32'(chan), 32'h0);
        chk("R1 reset rdata", rdata, 32'h0);
        rst_n = 1'b1;
        cyc("R1");
        chk("R1 chan after reset", 32'(chan), 32'h0);
        req = '0;
        rreg(addr_of(0), "R1");
        chk("R1 entry 0 cleared", rdata, 32'h0);
        rreg(addr_of(127), "R1");
        chk("R1 entry 127 cleared", rdata, 32'h0);

        // R2: request 5 to channel 7
        wreg(addr_of(5), 32'h87, "R2");
        req = '0; req[5] = 1'b1;
        cyc("R2");
        chk("R2 req5 -> ch7", 32'(chan), 32'h80);

        // R3: disabled entry with a channel number
        req = '0;
        wreg(addr_of(9), 32'h07, "R3");
        req[9] = 1'b1;
        cyc("R3");
        chk("R3 disabled entry blocks", 32'(chan), 32'h0);

        // R4 / R5: several lines on channel 7 across both windows
        req = '0;
        wreg(addr_of(10), 32'h87, "R4");
        wreg(16'h1118, 32'h87, "R5");
        req[5] = 1'b1; req[10] = 1'b1; req[70] = 1'b1; req[9] = 1'b1;
        cyc("R4");
        chk("R4 OR onto ch7", 32'(chan), 32'h80);
        req = '0; req[70] = 1'b1;
        cyc("R5");
        chk("R5 upper window req70", 32'(chan), 32'h80);
        req = '0;
        rreg(16'h1118, "R5");
        chk("R5 read req70", rdata, 32'h87);
        rreg(addr_of(6), "R5");
        chk("R5 req6 untouched", rdata, 32'h0);

        // R12: move request 5 to channel 31
        wreg(addr_of(5), 32'h9F, "R12");
        req[5] = 1'b1;
        cyc("R12");
        chk("R12 moved to ch31", 32'(chan), 32'h8000_0000);

        // R9: new entry takes effect one edge after the write edge
        wr = 1'b1; addr = addr_of(5); wdata = 32'h83;
        cyc("R9");
        wr = 1'b0;
        chk("R9 old route on write edge", 32'(chan), 32'h8000_0000);
        cyc("R9");
        chk("R9 new route next edge", 32'(chan), 32'h8);

        // R6: writing zero removes the line
        wreg(addr_of(5), 32'h0, "R6");
        cyc("R6");
        chk("R6 cleared entry silent", 32'(chan), 32'h0);
        req = '0;
        rreg(addr_of(5), "R6");
        chk("R6 read cleared", rdata, 32'h0);

        // R7: all-ones write reads back only the defined fields
        wreg(addr_of(20), 32'hFFFF_FFFF, "R7");
        rreg(addr_of(20), "R7");
        chk("R7 read fields", rdata, 32'h9F);

        // R8: accesses outside the windows or misaligned
        wreg(16'h0200, 32'h81, "R8");
        wreg(16'h0102, 32'h81, "R8");
        wreg(16'h0000, 32'h81, "R8");
        wreg(16'h1200, 32'h81, "R8");
        rreg(addr_of(0), "R8");
        chk("R8 entry 0 unchanged", rdata, 32'h0);
        rreg(16'h0104, "R8");
        chk("R8 entry 1 unchanged", rdata, 32'h0);
        req = '0; req[0] = 1'b1; req[1] = 1'b1; req[64] = 1'b1;
        cyc("R8");
        chk("R8 no route created", 32'(chan), 32'h0);
        req = '0;
        rreg(16'h0200, "R8");
        chk("R8 read outside", rdata, 32'h0);
        rreg(16'h0101, "R8");
        chk("R8 read misaligned", rdata, 32'h0);

        // R10: read and write on one edge return old contents
        rd = 1'b1; wr = 1'b1; addr = addr_of(20); wdata = 32'h82;
        cyc("R10");
        rd = 1'b0; wr = 1'b0;
        chk("R10 read old value", rdata, 32'h9F);
        rreg(addr_of(20), "R10");
        chk("R10 read new value", rdata, 32'h82);

        // R11: read data holds across idle cycles and other addresses
        addr = addr_of(9);
        cyc("R11");
        addr = 16'h0200;
        cyc("R11");
        chk("R11 rdata held", rdata, 32'h82);

        // Random mix of writes, reads and sparse requests (R4)
        for (int i = 0; i < 3000; i++) begin
            wr = ($urandom % 4 == 0);
            rd = ($urandom % 3 == 0);
            if ($urandom % 8 == 0) addr = 16'($urandom);
            else addr = addr_of(int'($urandom % NREQ));
            wdata = $urandom;
            req = '0;
            for (int k = 0; k < 4; k++) req[$urandom % NREQ] = 1'b1;
            cyc("R4 random");
        end
        wr = 1'b0; rd = 1'b0; req = '0;
        cyc("R4");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule